// File: doc/BRIEF.md
# Retriggerable one-shot pulse timer

This block is a 16-bit one-shot timer. Once armed and in one-shot mode, a trigger drives the pulse output high for a programmed number of count-source periods. The trigger comes either from a software strobe or from a rising edge on an external pin. When the count runs out, the output returns low and the interrupt request flag is raised. The count source is a one-cycle enable, `cs_en`, supplied from outside the block. A trigger that arrives while a pulse is running extends the pulse: the counter takes one more down-step, then reloads. Clearing the run bit ends any pulse at once, and the interrupt flag rises one clock later.

Software writes the mode and the trigger-source select while the timer is stopped. It writes the reload value at any time. Setting the run bit arms the timer. The interrupt flag stays set until `irq_clr` is pulsed. A newly written reload value takes effect at the next load.

The control FSM has three states:
- `ST_IDLE`: output low, no count in progress.
- `ST_ACTIVE`: output high, counting down.
- `ST_RELOAD`: output high, one count-source period in which the reload is done after a retrigger.

All transitions happen on a count-source tick, except the stop transition:
- `IDLE->ACTIVE` (trigger, reload non-zero).
- `IDLE->IDLE` (trigger, reload zero; flag set).
- `ACTIVE->ACTIVE` (decrement).
- `ACTIVE->IDLE` (underflow, the counter holds 1 at the tick).
- `ACTIVE->RELOAD` (retrigger; one decrement).
- `RELOAD->ACTIVE` (counter loaded from the reload register).
- any state `->IDLE` on stop. This one is taken on the clock edge, without waiting for a tick.

Top module: `oneshot_pulse_timer`

## Requirements
- R1: After reset, `pulse_out` and `irq` are 0, the mode is timer (code 0) and the run bit is 0.
- R2: A write to `cfg_mode`/`cfg_ext_sel` while the run bit is 1 is ignored; the stored mode keeps its value.
- R3: A configuration write, made while stopped, that changes the mode from another value to one-shot (code 2) sets `irq` at that clock edge. Writing one-shot while already in one-shot does not set `irq`.
- R4: With the run bit set, one-shot mode and `cfg_ext_sel`=0, a `sw_trig` pulse makes `pulse_out` rise on the next `cs_en` tick. The output then stays high for exactly N tick periods (N = reload value) and falls at the edge where the counter underflows. `irq` is set at that same edge.
- R5: A trigger with reload value 0 produces no pulse and sets `irq` on the first `cs_en` tick.
- R6: A trigger accepted while a pulse is active causes one down-count on the next tick and a reload from the reload register on the tick after. Counting then resumes, and the output stays high throughout.
- R7: A trigger arriving during the reload period after a retrigger is discarded. Several triggers within one tick period act as one.
- R8: Clearing the run bit while in one-shot mode forces `pulse_out` low at that edge and reloads the counter. `irq` is set one clock later.
- R9: With `cfg_ext_sel`=1, `trig_pin` passes through a two-flop synchroniser and a rising-edge detector. The output therefore cannot rise before the third clock edge after the pin rises. A pin held high triggers only once, and `sw_trig` is ignored.
- R10: `irq` stays set until `irq_clr` is pulsed; a clear then takes effect at the next edge. A set arriving in the same cycle wins.
- R11: Triggers are ignored while the run bit is 0 or the mode is not one-shot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_en | input | 1 | Count-source tick, one cycle wide |
| trig_pin | input | 1 | Asynchronous external trigger pin |
| cfg_we | input | 1 | Write strobe for mode and trigger select |
| cfg_mode | input | 2 | Mode: 0 timer, 1 event counter, 2 one-shot |
| cfg_ext_sel | input | 1 | 1 selects the external pin as trigger source |
| reload_we | input | 1 | Write strobe for the reload value |
| reload_val | input | 16 | Reload value (pulse length in ticks) |
| start_we | input | 1 | Write strobe for the run bit |
| start_val | input | 1 | New run bit value |
| sw_trig | input | 1 | Software trigger strobe |
| irq_clr | input | 1 | Clears the interrupt request flag |
| pulse_out | output | 1 | One-shot pulse output |
| irq | output | 1 | Interrupt request flag |

## Verification
A wrong FSM state or counter value shows up as a pulse whose length differs from the reload value measured in ticks. A spurious or missing pulse is another sign, and both become visible at the falling edge of `pulse_out`, within N+2 tick periods of the trigger. Faults in the flag path appear within one or two clocks of the event at `irq`. Such events include a mode entry, a stop, or an underflow. A broken synchroniser shows as a pulse that rises too early after the pin edge, or as repeated pulses from a held-high pin.

// File: rtl/ost_pkg.sv
package ost_pkg;
    typedef enum logic [1:0] {
        MODE_TIMER   = 2'd0,
        MODE_EVENT   = 2'd1,
        MODE_ONESHOT = 2'd2
    } op_mode_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_RELOAD = 2'd2
    } ost_state_t;
endpackage

// File: rtl/ost_trig_sync.sv
module ost_trig_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise
);
    // sh[STAGES-1] is the synchronised level, sh[STAGES] its delayed copy
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh <= '0;
        else        sh <= {sh[STAGES-1:0], pin};
    end

    assign rise = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/ost_core.sv
module ost_core
    import ost_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             trig_evt,
    input  logic             stop,
    input  logic [CNT_W-1:0] reload,
    output logic             pulse_out,
    output logic             done
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ost_state_t       state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             pend, pend_n;
    logic             accept, want;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            pend  <= 1'b0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
            pend  <= pend_n;
        end
    end

    // next state
    always_comb begin
        accept  = trig_evt && (state != ST_RELOAD);
        want    = pend || accept;
        state_n = state;
        cnt_n   = cnt;
        pend_n  = want;
        if (stop) begin
            state_n = ST_IDLE;
            cnt_n   = reload;
            pend_n  = 1'b0;
        end else if (tick) begin
            pend_n = 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (want && reload != '0) begin
                        state_n = ST_ACTIVE;
                        cnt_n   = reload;
                    end
                end
                ST_ACTIVE: begin
                    if (want) begin
                        state_n = ST_RELOAD;
                        cnt_n   = cnt - ONE;
                    end else if (cnt == ONE) begin
                        state_n = ST_IDLE;
                        cnt_n   = reload;
                    end else begin
                        cnt_n   = cnt - ONE;
                    end
                end
                ST_RELOAD: begin
                    state_n = ST_ACTIVE;
                    cnt_n   = reload;
                end
                default: begin
                    state_n = ST_IDLE;
                    cnt_n   = reload;
                end
            endcase
        end
    end

    // outputs
    always_comb begin
        pulse_out = (state != ST_IDLE);
        done      = tick && !stop &&
                    (((state == ST_IDLE) && want && (reload == '0)) ||
                     ((state == ST_ACTIVE) && !want && (cnt == ONE)));
    end
endmodule

// File: rtl/oneshot_pulse_timer.sv
module oneshot_pulse_timer
    import ost_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_en,
    input  logic             trig_pin,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_mode,
    input  logic             cfg_ext_sel,
    input  logic             reload_we,
    input  logic [CNT_W-1:0] reload_val,
    input  logic             start_we,
    input  logic             start_val,
    input  logic             sw_trig,
    input  logic             irq_clr,
    output logic             pulse_out,
    output logic             irq
);
    op_mode_t         mode_q;
    logic             ext_sel_q, run_q, irq_q, stop_d;
    logic [CNT_W-1:0] reload_q;
    logic             pin_rise, cfg_ok, mode_entry, is_os, stop, trig_evt;
    logic             core_done, irq_set;

    ost_trig_sync #(.STAGES(SYNC_STGS)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (trig_pin),
        .rise (pin_rise)
    );

    always_comb begin
        is_os      = (mode_q == MODE_ONESHOT);
        cfg_ok     = cfg_we && !run_q;
        mode_entry = cfg_ok && (op_mode_t'(cfg_mode) == MODE_ONESHOT) && !is_os;
        stop       = start_we && !start_val && run_q && is_os;
        trig_evt   = run_q && is_os && (ext_sel_q ? pin_rise : sw_trig);
        irq_set    = core_done || mode_entry || stop_d;
    end

    ost_core #(.CNT_W(CNT_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (cs_en),
        .trig_evt (trig_evt),
        .stop     (stop),
        .reload   (reload_q),
        .pulse_out(pulse_out),
        .done     (core_done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= MODE_TIMER;
            ext_sel_q <= 1'b0;
            run_q     <= 1'b0;
            reload_q  <= '0;
            stop_d    <= 1'b0;
            irq_q     <= 1'b0;
        end else begin
            if (cfg_ok) begin
                mode_q    <= op_mode_t'(cfg_mode);
                ext_sel_q <= cfg_ext_sel;
            end
            if (start_we)  run_q    <= start_val;
            if (reload_we) reload_q <= reload_val;
            stop_d <= stop;
            if (irq_set)      irq_q <= 1'b1;
            else if (irq_clr) irq_q <= 1'b0;
        end
    end

    assign irq = irq_q;
endmodule

// File: rtl/ost_timer_chk.sv
module ost_timer_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_we,
    input logic [1:0] cfg_mode,
    input logic       start_we,
    input logic       start_val,
    input logic       irq_clr,
    input logic       pulse_out,
    input logic       irq,
    input logic       run_q,
    input logic [1:0] mode_q,
    input logic       irq_set
);
    // R8
    stop_out_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_we && !start_val && run_q && mode_q == 2'd2) |=> !pulse_out);

    // R8
    stop_irq_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_we && !start_val && run_q && mode_q == 2'd2) |-> ##2 irq);

    // R3
    mode_entry_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !run_q && cfg_mode == 2'd2 && mode_q != 2'd2) |=> irq);

    // R2
    mode_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |=> $stable(mode_q));

    // R10
    irq_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr && !irq_set) |=> !irq);

    // R11
    idle_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_q && !pulse_out) |=> !pulse_out);
endmodule

bind oneshot_pulse_timer ost_timer_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_mode (cfg_mode),
    .start_we (start_we),
    .start_val(start_val),
    .irq_clr  (irq_clr),
    .pulse_out(pulse_out),
    .irq      (irq),
    .run_q    (run_q),
    .mode_q   (mode_q),
    .irq_set  (irq_set)
);

// File: tb/oneshot_pulse_timer_bench.sv
`timescale 1ns/1ps
module oneshot_pulse_timer_bench;
    localparam int TPT = 4;  // clocks per count-source tick

    logic        clk = 0, rst_n = 0, cs_en = 0, trig_pin = 0;
    logic        cfg_we = 0, cfg_ext_sel = 0, reload_we = 0;
    logic [1:0]  cfg_mode = 0;
    logic [15:0] reload_val = 0;
    logic        start_we = 0, start_val = 0, sw_trig = 0, irq_clr = 0;
    logic        pulse_out, irq;

    int compared = 0, mismatched = 0;
    int cs_ph = 0;
    int exp_q[$];
    string tag_q[$];
    int hi_cnt = 0;
    logic prev_out = 0;
    bit done = 0;

    always #4 clk = ~clk;

    oneshot_pulse_timer u_oneshot_pulse_timer (
        .clk(clk), .rst_n(rst_n), .cs_en(cs_en), .trig_pin(trig_pin),
        .cfg_we(cfg_we), .cfg_mode(cfg_mode), .cfg_ext_sel(cfg_ext_sel),
        .reload_we(reload_we), .reload_val(reload_val),
        .start_we(start_we), .start_val(start_val), .sw_trig(sw_trig),
        .irq_clr(irq_clr), .pulse_out(pulse_out), .irq(irq)
    );

    always @(negedge clk) begin
        cs_ph = (cs_ph + 1) % TPT;
        cs_en = (cs_ph == TPT - 1);
    end

    task automatic chk(string req, int act, int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // driver side of the scoreboard: expected pulse width in clock cycles
    task automatic expect_pulse(int ticks, string req);
        exp_q.push_back(ticks * TPT);
        tag_q.push_back(req);
    endtask

    // monitor: measures every completed high pulse
    always @(negedge clk) begin
        if (pulse_out) hi_cnt++;
        else if (prev_out) begin
            if (exp_q.size() == 0) chk("unexpected pulse (R5/R9/R11)", hi_cnt, 0);
            else begin
                string t = tag_q.pop_front();
                chk(t, hi_cnt, exp_q.pop_front());
            end
            hi_cnt = 0;
        end
        prev_out = pulse_out;
    end

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cfg(logic [1:0] m, logic ext);
        cfg_we = 1; cfg_mode = m; cfg_ext_sel = ext; cyc(1); cfg_we = 0;
    endtask
    task automatic wr_reload(int v);
        reload_we = 1; reload_val = 16'(v); cyc(1); reload_we = 0;
    endtask
    task automatic wr_start(logic v);
        start_we = 1; start_val = v; cyc(1); start_we = 0;
    endtask
    task automatic pulse_sw;
        sw_trig = 1; cyc(1); sw_trig = 0;
    endtask
    task automatic clr_irq;
        irq_clr = 1; cyc(1); irq_clr = 0;
    endtask
    task automatic wait_ticks(int k);
        repeat (k) @(posedge clk iff cs_en);
        @(negedge clk);
    endtask
    task automatic wait_level(logic lvl, string req);
        for (int i = 0; i < 400 && pulse_out != lvl; i++) @(negedge clk);
        if (pulse_out != lvl) chk(req, pulse_out, lvl);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        cyc(3); rst_n = 1; cyc(1);
        chk("R1 pulse_out after reset", pulse_out, 0);
        chk("R1 irq after reset", irq, 0);

        // R11: timer mode, running: trigger ignored
        wr_reload(3); wr_start(1); pulse_sw(); cyc(12);
        chk("R11 no pulse in timer mode", pulse_out, 0);
        wr_start(0); cyc(3);
        chk("R11 no irq leaving timer mode", irq, 0);

        // R3: enter one-shot
        wr_cfg(2'd2, 0);
        chk("R3 mode entry sets irq", irq, 1);
        clr_irq();
        chk("R10 irq cleared", irq, 0);
        wr_cfg(2'd2, 0); cyc(1);
        chk("R3 re-select one-shot no irq", irq, 0);

        // R4: plain pulse, N=5
        wr_reload(5); wr_start(1);
        // R11 stopped run bit: covered by above; now running
        expect_pulse(5, "R4 pulse width N=5");
        pulse_sw(); wait_level(1, "R4 rise"); wait_level(0, "R4 fall");
        chk("R4 irq at underflow", irq, 1);
        clr_irq();

        // R5: reload zero
        wr_reload(0); pulse_sw(); cyc(2 * TPT);
        chk("R5 zero reload sets irq", irq, 1);
        chk("R5 zero reload no pulse", pulse_out, 0);
        clr_irq();

        // R6: retrigger after two ticks, N=6 -> 10 ticks
        wr_reload(6);
        expect_pulse(10, "R6 retrigger width");
        pulse_sw(); wait_level(1, "R6 rise");
        wait_ticks(2); pulse_sw();
        wait_level(0, "R6 fall"); clr_irq();

        // R7: trigger during reload period discarded
        expect_pulse(10, "R7 reload-period trigger ignored");
        pulse_sw(); wait_level(1, "R7 rise");
        wait_ticks(2); pulse_sw(); wait_ticks(1); pulse_sw();
        wait_level(0, "R7 fall"); clr_irq();

        // R8: stop mid-pulse, N=20: 3 ticks + 1 clock high
        wr_reload(20);
        exp_q.push_back(3 * TPT + 1); tag_q.push_back("R8 truncated width");
        pulse_sw(); wait_level(1, "R8 rise"); wait_ticks(3);
        wr_start(0);
        chk("R8 out low after stop", pulse_out, 0);
        chk("R8 irq not yet set", irq, 0);
        cyc(1);
        chk("R8 irq one clock later", irq, 1);
        clr_irq();

        // R2: mode write while running ignored
        wr_reload(3); wr_start(1); wr_cfg(2'd0, 0);
        expect_pulse(3, "R2 still one-shot after locked write");
        pulse_sw(); wait_level(1, "R2 rise"); wait_level(0, "R2 fall");
        clr_irq();
        wr_start(0); cyc(3);
        chk("R2 stop irq proves one-shot mode kept", irq, 1);
        clr_irq();

        // R9: external trigger
        wr_cfg(2'd2, 1); cyc(1);
        chk("R3 ext select write no irq", irq, 0);
        wr_start(1);
        expect_pulse(3, "R9 external trigger width");
        trig_pin = 1; cyc(1);
        chk("R9 no rise after 1 edge", pulse_out, 0);
        cyc(1);
        chk("R9 no rise after 2 edges", pulse_out, 0);
        wait_level(1, "R9 rise"); wait_level(0, "R9 fall");
        cyc(30);
        chk("R9 held pin single pulse", exp_q.size(), 0);
        pulse_sw(); cyc(3 * TPT);
        chk("R9 sw_trig ignored with pin select", pulse_out, 0);
        trig_pin = 0; cyc(4);

        chk("scoreboard drained", exp_q.size(), 0);
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule